// File: doc/BRIEF.md
# LDPC Variable Node with Serial Swap Loader

This block is one variable node of a parallel LDPC decoder. It keeps two small memories indexed by a word address. The first holds the channel log-likelihood ratio of each bit. The second holds the running sum of the check-node messages that came back to that bit. When the decoder sends, the node adds the stored LLR to the sum from the previous iteration and saturates the result to form the outgoing message. The sign of the same total gives the hard decision. When the decoder gathers, each returning message is added into the sum word. The first message of an iteration overwrites the old value instead of adding to it. The node never keeps the individual per-edge messages.

Frames are loaded and unloaded over a serial chain. Each node has one chain register, linked to its neighbours while the load mode is active. A shift strobe moves the chain by one node. A swap strobe exchanges the chain register with the LLR word at the selected address in a single cycle. A new frame can therefore be written while the previous contents are read out. While the load mode is active, decode steps are suspended and have no effect.

Top module: `vnode_core`

## Requirements
- R1: After a synchronous reset, `out_vld`, `out_msg`, `hard_bit` and `chain_out` are all 0.
- R2: When `ld_mode`=1, `ld_shift`=1 and `ld_swap`=0, `chain_out` equals the `chain_in` value from the previous edge. The chain register holds its value when `ld_mode`=1 with neither strobe set, and whenever `ld_mode`=0.
- R3: When `ld_mode`=1 and `ld_swap`=1, on the same edge the LLR word at `addr` moves into the chain register and the old chain value moves into that word. A swap takes priority over a shift set in the same cycle.
- R4: While `ld_mode`=1, `step` is ignored. No `out_vld` follows it and the stored sums are left unchanged.
- R5: A send is `step`=1 with `phase`=0. Two edges after a send, `out_vld`=1 and `out_msg` is the signed LLR plus the stored sum, clamped to ±(2^(MSG_W-1)-1), which is ±255 by default. The sum term is 0 when `first_iter`=1.
- R6: A gather is `step`=1 with `phase`=1 and `in_msg` signed. With `first_visit`=1 the sum word becomes the clamped `in_msg`. Otherwise it becomes the clamp of the old sum plus `in_msg`, using the same ±(2^(SUM_W-1)-1) bound. A gather never raises `out_vld`.
- R7: Gathers to one address on consecutive cycles lose no update. A send to that address issued on the very next cycle already uses the full sum.
- R8: `hard_bit`, updated with each send result, is 1 exactly when the unclamped LLR plus the sum term is negative.
- R9: `out_vld` is 1 only two edges after a send. `out_msg` and `hard_bit` keep their values while `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_mode | input | 1 | Load mode: enables the chain and suspends decoding |
| ld_shift | input | 1 | Shift the chain by one node |
| ld_swap | input | 1 | Exchange the chain register with the LLR word at `addr` |
| chain_in | input | LLR_W | Chain input from the previous node |
| chain_out | output | LLR_W | Chain register, sent to the next node |
| addr | input | AW | Word address for swaps and decode steps |
| step | input | 1 | Decode step strobe |
| phase | input | 1 | 0 = send, 1 = gather |
| first_iter | input | 1 | Send uses a zero sum term |
| first_visit | input | 1 | Gather overwrites instead of accumulating |
| in_msg | input | MSG_W | Returning check-node message, signed |
| out_vld | output | 1 | Outgoing message valid |
| out_msg | output | MSG_W | Outgoing message, signed, saturated |
| hard_bit | output | 1 | Hard decision from the sign of the total |

## Verification
The bench drives back-to-back gathers to one address, then a send on the very next cycle. A node without write-back forwarding would drop updates there or send a stale sum. It loads extreme LLRs such as -256 and +255 and drives messages at both rails. Wrong clamping would show up as wrapped outgoing values or as a hard decision taken from the clamped sign. It also issues swap and shift together, swaps at the last address, and sends decode steps during load mode. A wrong priority, an address-decode slip or a missing suspend each shows up as a chain value, an LLR or a sum that differs from the model.

// File: rtl/vn_pkg.sv
package vn_pkg;
  typedef enum logic {
    PH_SEND   = 1'b0,
    PH_GATHER = 1'b1
  } vn_phase_e;
endpackage

// File: rtl/vn_llr_store.sv
module vn_llr_store #(
  parameter int LLR_W = 9,
  parameter int DEPTH = 180,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_mode,
  input  logic             ld_shift,
  input  logic             ld_swap,
  input  logic [AW-1:0]    addr,
  input  logic [LLR_W-1:0] chain_in,
  output logic [LLR_W-1:0] chain_q,
  output logic [LLR_W-1:0] llr_rd
);
  logic [LLR_W-1:0] mem [DEPTH];
  logic             swap_en;

  assign swap_en = ld_mode && ld_swap;

  // Read-first memory: the old word leaves while the chain word enters
  always_ff @(posedge clk) begin
    if (swap_en) mem[addr] <= chain_q;
    llr_rd <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else if (ld_mode) begin
      if (ld_swap)       chain_q <= mem[addr];
      else if (ld_shift) chain_q <= chain_in;
    end
  end
endmodule

// File: rtl/vn_sum_store.sv
module vn_sum_store #(
  parameter int SUM_W = 9,
  parameter int MSG_W = 9,
  parameter int DEPTH = 180,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_en,
  input  logic                    first_visit,
  input  logic [AW-1:0]           addr,
  input  logic signed [MSG_W-1:0] msg,
  output logic signed [SUM_W-1:0] sum_now
);
  localparam int SW = SUM_W + 2;
  localparam logic signed [SW-1:0] S_MAX = SW'((1 <<< (SUM_W - 1)) - 1);

  logic signed [SUM_W-1:0] mem [DEPTH];
  logic signed [SUM_W-1:0] rd_q, wb_data, new_sum;
  logic signed [MSG_W-1:0] p_msg;
  logic signed [SW-1:0]    wide;
  logic [AW-1:0]           p_addr, wb_addr;
  logic                    p_acc, p_first, wb_vld;

  // Forward the write of the previous cycle, missed by the read-first port
  assign sum_now = (wb_vld && wb_addr == p_addr) ? wb_data : rd_q;

  always_comb begin
    if (p_first) wide = SW'(p_msg);
    else         wide = SW'(sum_now) + SW'(p_msg);
    if (wide > S_MAX)       new_sum = S_MAX[SUM_W-1:0];
    else if (wide < -S_MAX) new_sum = -S_MAX[SUM_W-1:0];
    else                    new_sum = wide[SUM_W-1:0];
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[addr];
    if (p_acc) mem[p_addr] <= new_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_acc  <= 1'b0;
      wb_vld <= 1'b0;
    end else begin
      p_acc  <= acc_en;
      wb_vld <= p_acc;
    end
    p_first <= first_visit;
    p_addr  <= addr;
    p_msg   <= msg;
    wb_addr <= p_addr;
    wb_data <= new_sum;
  end
endmodule

// File: rtl/vn_out_stage.sv
module vn_out_stage #(
  parameter int LLR_W = 9,
  parameter int SUM_W = 9,
  parameter int MSG_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  logic                    zero_sum,
  input  logic [LLR_W-1:0]        llr_in,
  input  logic signed [SUM_W-1:0] sum_in,
  output logic                    out_vld,
  output logic [MSG_W-1:0]        out_msg,
  output logic                    hard
);
  localparam int TW = LLR_W + SUM_W + 2;
  localparam logic signed [TW-1:0] M_MAX = TW'((1 <<< (MSG_W - 1)) - 1);

  logic signed [TW-1:0] llr_x, sum_x, total, clamped;

  always_comb begin
    llr_x = TW'($signed(llr_in));
    sum_x = zero_sum ? '0 : TW'(sum_in);
    total = llr_x + sum_x;
    if (total > M_MAX)       clamped = M_MAX;
    else if (total < -M_MAX) clamped = -M_MAX;
    else                     clamped = total;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_msg <= '0;
      hard    <= 1'b0;
    end else begin
      out_vld <= go;
      if (go) begin
        out_msg <= clamped[MSG_W-1:0];
        hard    <= total[TW-1];
      end
    end
  end
endmodule

// File: rtl/vnode_core.sv
module vnode_core #(
  parameter int LLR_W = 9,
  parameter int SUM_W = 9,
  parameter int MSG_W = 9,
  parameter int DEPTH = 180,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_mode,
  input  logic             ld_shift,
  input  logic             ld_swap,
  input  logic [LLR_W-1:0] chain_in,
  output logic [LLR_W-1:0] chain_out,
  input  logic [AW-1:0]    addr,
  input  logic             step,
  input  logic             phase,
  input  logic             first_iter,
  input  logic             first_visit,
  input  logic [MSG_W-1:0] in_msg,
  output logic             out_vld,
  output logic [MSG_W-1:0] out_msg,
  output logic             hard_bit
);
  import vn_pkg::*;

  logic                    step_ok, send_go, acc_en;
  logic                    send_p, first_p;
  logic [LLR_W-1:0]        llr_rd;
  logic signed [SUM_W-1:0] sum_now;

  assign step_ok = step && !ld_mode;
  assign send_go = step_ok && (vn_phase_e'(phase) == PH_SEND);
  assign acc_en  = step_ok && (vn_phase_e'(phase) == PH_GATHER);

  always_ff @(posedge clk) begin
    if (rst) send_p <= 1'b0;
    else     send_p <= send_go;
    first_p <= first_iter;
  end

  vn_llr_store #(.LLR_W(LLR_W), .DEPTH(DEPTH)) u_llr (
    .clk      (clk),
    .rst      (rst),
    .ld_mode  (ld_mode),
    .ld_shift (ld_shift),
    .ld_swap  (ld_swap),
    .addr     (addr),
    .chain_in (chain_in),
    .chain_q  (chain_out),
    .llr_rd   (llr_rd)
  );

  vn_sum_store #(.SUM_W(SUM_W), .MSG_W(MSG_W), .DEPTH(DEPTH)) u_sum (
    .clk         (clk),
    .rst         (rst),
    .acc_en      (acc_en),
    .first_visit (first_visit),
    .addr        (addr),
    .msg         ($signed(in_msg)),
    .sum_now     (sum_now)
  );

  vn_out_stage #(.LLR_W(LLR_W), .SUM_W(SUM_W), .MSG_W(MSG_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .go       (send_p),
    .zero_sum (first_p),
    .llr_in   (llr_rd),
    .sum_in   (sum_now),
    .out_vld  (out_vld),
    .out_msg  (out_msg),
    .hard     (hard_bit)
  );
endmodule

// File: rtl/vnode_core_chk.sv
module vnode_core_chk #(
  parameter int LLR_W = 9,
  parameter int MSG_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             ld_mode,
  input logic             ld_shift,
  input logic             ld_swap,
  input logic [LLR_W-1:0] chain_in,
  input logic [LLR_W-1:0] chain_out,
  input logic             step,
  input logic             phase,
  input logic             out_vld,
  input logic [MSG_W-1:0] out_msg,
  input logic             hard_bit
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_vld && !hard_bit && out_msg == '0 && chain_out == '0));

  // R2
  chain_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_mode && ld_shift && !ld_swap) |=> (chain_out == $past(chain_in)));

  // R2
  chain_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_mode |=> $stable(chain_out));

  // R4
  load_suspend_chk: assert property (@(posedge clk) disable iff (rst)
    ld_mode |-> ##2 !out_vld);

  // R5
  send_result_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !phase && !ld_mode) |-> ##2 out_vld);

  // R6
  gather_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (step && phase) |-> ##2 !out_vld);

  // R9
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(step && !phase && !ld_mode, 2));

  // R9
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> ($stable(out_msg) && $stable(hard_bit)));

  // R8
  hard_sign_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (hard_bit == out_msg[MSG_W-1]));
endmodule

bind vnode_core vnode_core_chk #(.LLR_W(LLR_W), .MSG_W(MSG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ld_mode   (ld_mode),
  .ld_shift  (ld_shift),
  .ld_swap   (ld_swap),
  .chain_in  (chain_in),
  .chain_out (chain_out),
  .step      (step),
  .phase     (phase),
  .out_vld   (out_vld),
  .out_msg   (out_msg),
  .hard_bit  (hard_bit)
);

// File: tb/tb_vnode_core.sv
module tb_vnode_core;
  localparam int W     = 9;
  localparam int DEPTH = 180;
  localparam int AW    = $clog2(DEPTH);
  localparam int MAXV  = 255;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          ld_mode = 0, ld_shift = 0, ld_swap = 0;
  logic [W-1:0]  chain_in = '0, chain_out;
  logic [AW-1:0] addr = '0;
  logic          step = 0, phase = 0, first_iter = 0, first_visit = 0;
  logic [W-1:0]  in_msg = '0, out_msg;
  logic          out_vld, hard_bit;

  vnode_core dut (
    .clk(clk), .rst(rst), .ld_mode(ld_mode), .ld_shift(ld_shift),
    .ld_swap(ld_swap), .chain_in(chain_in), .chain_out(chain_out),
    .addr(addr), .step(step), .phase(phase), .first_iter(first_iter),
    .first_visit(first_visit), .in_msg(in_msg), .out_vld(out_vld),
    .out_msg(out_msg), .hard_bit(hard_bit)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural reference state
  int llr_m [DEPTH];
  bit llr_k [DEPTH];
  int sum_m [DEPTH];
  int chain_m = 0;
  bit chain_k = 1;
  int s1_vld = 0, s1_msg = 0, s1_hard = 0;
  int o_vld = 0, o_msg = 0, o_hard = 0;
  string chain_tag = "R1";
  string msg_tag = "R1";
  bit visited [DEPTH];

  function automatic int sx(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int clampv(int v);
    if (v > MAXV) return MAXV;
    if (v < -MAXV) return -MAXV;
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int a, tot, t;
    a = int'(addr);
    if (rst) begin
      chain_m = 0; chain_k = 1;
      o_vld = 0; o_msg = 0; o_hard = 0; s1_vld = 0;
      return;
    end
    if (s1_vld != 0) begin
      o_vld = 1; o_msg = s1_msg; o_hard = s1_hard;
    end else o_vld = 0;
    s1_vld = 0;
    if (ld_mode) begin
      if (ld_swap) begin
        t = llr_m[a]; llr_m[a] = chain_m; chain_m = t;
        tot = int'(llr_k[a]); llr_k[a] = chain_k; chain_k = (tot != 0);
      end else if (ld_shift) begin
        chain_m = sx(chain_in); chain_k = 1;
      end
    end else if (step) begin
      if (!phase) begin
        tot = llr_m[a] + (first_iter ? 0 : sum_m[a]);
        s1_vld = 1; s1_msg = clampv(tot); s1_hard = (tot < 0) ? 1 : 0;
      end else begin
        sum_m[a] = first_visit ? clampv(sx(in_msg)) : clampv(sum_m[a] + sx(in_msg));
      end
    end
  endtask

  task automatic compare();
    chk("R9", int'(out_vld), o_vld);
    chk((o_vld != 0) ? msg_tag : "R9", sx(out_msg), o_msg);
    chk("R8", int'(hard_bit), o_hard);
    if (chain_k) chk(chain_tag, sx(chain_out), chain_m);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic clr();
    ld_mode = 0; ld_shift = 0; ld_swap = 0; step = 0; phase = 0;
    first_iter = 0; first_visit = 0;
  endtask

  task automatic shift_in(int v);
    clr(); ld_mode = 1; ld_shift = 1; chain_in = W'(v); tick();
  endtask

  task automatic swap_at(int a, bit also_shift);
    clr(); ld_mode = 1; ld_swap = 1; ld_shift = also_shift; addr = AW'(a); tick();
  endtask

  task automatic send(int a, bit fi);
    clr(); step = 1; phase = 0; addr = AW'(a); first_iter = fi; tick();
  endtask

  task automatic gather(int a, bit fv, int m);
    clr(); step = 1; phase = 1; addr = AW'(a); first_visit = fv;
    in_msg = W'(m); tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin clr(); tick(); end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin llr_k[i] = 0; llr_m[i] = 0; sum_m[i] = 0; end
    @(negedge clk);
    rst = 1; tick(); tick(); tick();
    rst = 0; clr(); tick();
    // R1 reset state
    chk("R1", int'(out_vld), 0);
    chk("R1", sx(out_msg), 0);
    chk("R1", int'(hard_bit), 0);
    chk("R1", sx(chain_out), 0);

    // R2 shifting and holding
    chain_tag = "R2";
    shift_in(17); shift_in(-3); shift_in(-256);
    clr(); ld_mode = 1; chain_in = W'(99); tick();
    clr(); ld_shift = 1; chain_in = W'(55); tick();
    shift_in(255);

    // R3 load frame through swaps, old words enter the chain
    chain_tag = "R3";
    for (int a = 0; a < 16; a++) begin
      shift_in((a * 37) % 512 - 256);
      chain_tag = "R3";
      swap_at(a, 0);
    end
    shift_in(-256); swap_at(16, 0);
    shift_in(255);  swap_at(17, 0);
    shift_in(-1);   swap_at(DEPTH - 1, 0);
    // swap and shift together: swap wins
    shift_in(100); chain_in = W'(7); swap_at(5, 1);
    chain_in = W'(33); swap_at(5, 1);
    // unload while reloading
    shift_in(-77); swap_at(DEPTH - 1, 0);
    shift_in(-1);  swap_at(DEPTH - 1, 0);
    idle(2);

    // R5 first iteration sends, sum term zero
    msg_tag = "R5";
    for (int a = 0; a < 18; a++) send(a, 1);
    send(DEPTH - 1, 1);
    idle(2);

    // R6 gathers with overwrite and accumulate, rails included
    for (int a = 0; a < 18; a++) gather(a, 1, (a * 53) % 400 - 200);
    gather(3, 0, 255); gather(3, 0, 255); gather(3, 0, 255);
    gather(4, 0, -256); gather(4, 0, -256);
    gather(DEPTH - 1, 1, -9);
    msg_tag = "R6";
    idle(2);
    for (int a = 0; a < 18; a++) send(a, 0);
    send(DEPTH - 1, 0);
    idle(2);

    // R7 back-to-back gathers then an immediate send
    msg_tag = "R7";
    gather(8, 1, 20); gather(8, 0, 30); gather(8, 0, -5); send(8, 0);
    gather(9, 1, -100); gather(9, 0, -100); send(9, 0); send(9, 0);
    gather(10, 1, 1); gather(11, 1, 2); gather(10, 0, 3); send(10, 0); send(11, 0);
    idle(3);

    // R4 decode steps during load mode are ignored
    clr(); ld_mode = 1; step = 1; phase = 1; addr = AW'(8); in_msg = W'(-200); tick();
    clr(); ld_mode = 1; step = 1; phase = 0; addr = AW'(8); tick();
    clr(); ld_mode = 1; step = 1; phase = 1; first_visit = 1; addr = AW'(9); in_msg = W'(77); tick();
    chk("R4", int'(out_vld), 0);
    clr(); tick();
    chk("R4", int'(out_vld), 0);
    msg_tag = "R4";
    send(8, 0); send(9, 0); idle(2);

    // randomised iterations over the loaded addresses
    for (int it = 0; it < 10; it++) begin
      msg_tag = "R5";
      for (int a = 0; a < 18; a++) send(a, (it == 0) ? 1'b1 : 1'b0);
      for (int a = 0; a < 18; a++) visited[a] = 0;
      msg_tag = "R6";
      for (int r = 0; r < 3; r++) begin
        for (int a = 0; a < 18; a++) begin
          if (r == 0 || $urandom_range(2, 0) != 0) begin
            gather(a, !visited[a], int'($urandom_range(511, 0)) - 256);
            visited[a] = 1;
            if ($urandom_range(3, 0) == 0) gather(a, 0, int'($urandom_range(511, 0)) - 256);
          end
        end
      end
      if ((it % 2) == 1) idle(1);
    end
    msg_tag = "R8";
    for (int a = 0; a < 18; a++) send(a, 0);
    idle(3);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule